// File: doc/BRIEF.md
# SIMD Byte Load-and-Place Unit

This unit carries out one media-extension load. On a start pulse it decodes a 32-bit instruction word and looks up a base value on a general-purpose register read port. It adds a signed 8-bit displacement to that base to form a byte address. It then issues a single-byte read over a valid/ready request channel and waits for the response byte. The byte is written into one of sixteen 32-bit extension registers. Where it lands is set by a 3-bit placement code. Four codes insert the byte into a single lane and keep the other three lanes. The other four codes build a new packed word from the byte alone: zero-extended halfwords, high-byte halfwords, sign-extended halfwords, or the byte copied into all four lanes.

The sixteen-entry extension register file lives inside the unit. A separate combinational debug read port lets any entry be observed at any time. The unit runs one instruction at a time. It is busy from the accepted start until the cycle in which the response is written, and a start pulse is ignored while it is busy.

Top module: `bytePlaceLoad`

## Requirements
- R1: Instruction fields are decoded from fixed positions: destination extension register from bits [9:6], displacement from bits [17:10], placement code from bits [20:18], base register index from bits [25:21]. While idle, `gprIdx` equals bits [25:21] of `instr`.
- R2: The request address is the base register value plus the displacement, sign-extended to 32 bits. It appears on `memReqAddr` with `memReqValid` in the cycle after the start is accepted, and it stays stable until `memReqReady` is seen.
- R3: Placement codes 0, 1, 2 and 3 write the byte into bits [7:0], [15:8], [23:16] and [31:24] of the destination respectively, and leave the other 24 bits at their previous value.
- R4: Placement code 4 writes {8'h00, b, 8'h00, b}.
- R5: Placement code 5 writes {b, 8'h00, b, 8'h00}.
- R6: Placement code 6 writes each halfword as the byte sign-extended to 16 bits: {{8{b[7]}}, b, {8{b[7]}}, b}.
- R7: Placement code 7 writes {b, b, b, b}, independent of the old register value.
- R8: `busy` rises only after an accepted start. A start while busy issues no memory request and changes no register.
- R9: `done` is a one-cycle pulse in the cycle the response byte is accepted. The destination is written on that clock edge, and only the destination changes.
- R10: Extension register 0 always reads zero, and writes to it are discarded.
- R11: After reset, every extension register reads zero, and `busy`, `done` and `memReqValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction (accepted while idle) |
| instr | input | 32 | Instruction word |
| gprIdx | output | 5 | Base register index to the GPR read port |
| gprData | input | 32 | Base register value returned combinationally |
| memReqValid | output | 1 | Byte read request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | 32 | Byte address of the request |
| memRspValid | input | 1 | Response byte valid |
| memRspData | input | 8 | Response byte |
| busy | output | 1 | Instruction in flight |
| done | output | 1 | One-cycle completion pulse |
| dbgIdx | input | 4 | Debug read index into the extension registers |
| dbgData | output | 32 | Debug read data |

## Verification
The request appears on the edge after the accepted start and is held until the edge where ready is high. The bench's memory responder records the address at the falling edge where it raises ready, then waits a programmable number of cycles before it drives the response. `done` is combinational from the response valid in the wait state, so the monitor samples it 1 ns after the falling edge where the responder raised valid. The register write lands on the following rising edge, so the monitor sweeps all sixteen registers through the debug port just after that edge, against its own shadow model. In the same window it confirms that `done` has already dropped.

// File: rtl/bplPkg.sv
`timescale 1ns/1ps
package bplPkg;
  localparam int BYTE_W   = 8;
  localparam int LANES    = 4;
  localparam int DATA_W   = BYTE_W * LANES;
  localparam int HALF_W   = 2 * BYTE_W;
  localparam int HALVES   = DATA_W / HALF_W;
  localparam int INSTR_W  = 32;
  localparam int DISP_W   = 8;
  localparam int MODE_W   = 3;
  // field positions the decoder depends on
  localparam int DEST_LSB = 6;
  localparam int DISP_LSB = 10;
  localparam int MODE_LSB = 18;
  localparam int BASE_LSB = 21;

  typedef enum logic [MODE_W-1:0] {
    PLACE_LANE0  = 3'd0,
    PLACE_LANE1  = 3'd1,
    PLACE_LANE2  = 3'd2,
    PLACE_LANE3  = 3'd3,
    PLACE_HALFLO = 3'd4,
    PLACE_HALFHI = 3'd5,
    PLACE_HALFSX = 3'd6,
    PLACE_REPL   = 3'd7
  } placeMode_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } ctrlState_t;

  typedef struct packed {
    logic capture;
    logic commit;
  } ctrlStrobe_t;
endpackage

// File: rtl/bplXregFile.sv
`timescale 1ns/1ps
module bplXregFile
  import bplPkg::*;
#(
  parameter int XREG_NUM = 16,
  localparam int XIDX_W  = $clog2(XREG_NUM)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [XIDX_W-1:0] wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [XIDX_W-1:0] rdIdxA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [XIDX_W-1:0] rdIdxB,
  output logic [DATA_W-1:0] rdDataB
);
  logic [XREG_NUM-1:0][DATA_W-1:0] slotVal;

  for (genvar i = 0; i < XREG_NUM; i++) begin : gSlot
    if (i == 0) begin : gZero
      assign slotVal[i] = '0;
    end else begin : gReg
      logic [DATA_W-1:0] slotQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          slotQ <= '0;
        end else if (wrEn && (wrIdx == XIDX_W'(i))) begin
          slotQ <= wrData;
        end
      end
      assign slotVal[i] = slotQ;
    end
  end

  assign rdDataA = slotVal[rdIdxA];
  assign rdDataB = slotVal[rdIdxB];

  // R9
  write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIdx != '0) |=> slotVal[$past(wrIdx)] == $past(wrData));
endmodule

// File: rtl/bplCtrl.sv
`timescale 1ns/1ps
module bplCtrl
  import bplPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        memReqReady,
  input  logic        memRspValid,
  output logic        memReqValid,
  output logic        busy,
  output logic        done,
  output ctrlStrobe_t strobe
);
  ctrlState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (start)       stateD = ST_REQ;
      ST_REQ:  if (memReqReady) stateD = ST_WAIT;
      ST_WAIT: if (memRspValid) stateD = ST_IDLE;
      default:                  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign strobe.capture = (stateQ == ST_IDLE) && start;
  assign strobe.commit  = (stateQ == ST_WAIT) && memRspValid;
  assign memReqValid    = (stateQ == ST_REQ);
  assign busy           = (stateQ != ST_IDLE);
  assign done           = strobe.commit;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/bplDatapath.sv
`timescale 1ns/1ps
module bplDatapath
  import bplPkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int XREG_NUM = 16,
  parameter int GPR_NUM  = 32,
  localparam int XIDX_W  = $clog2(XREG_NUM),
  localparam int GIDX_W  = $clog2(GPR_NUM)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [INSTR_W-1:0] instr,
  output logic [GIDX_W-1:0]  gprIdx,
  input  logic [ADDR_W-1:0]  gprData,
  output logic [ADDR_W-1:0]  memReqAddr,
  input  logic [BYTE_W-1:0]  memRspData,
  input  logic [XIDX_W-1:0]  dbgIdx,
  output logic [DATA_W-1:0]  dbgData
);
  logic [XIDX_W-1:0] destIdx, destQ;
  logic [DISP_W-1:0] dispRaw;
  placeMode_t        modeIn, modeQ;
  logic [ADDR_W-1:0] effAddr, addrQ;
  logic [DATA_W-1:0] oldVal, placed;
  logic [HALF_W-1:0] halfPat;

  assign destIdx = instr[DEST_LSB +: XIDX_W];
  assign dispRaw = instr[DISP_LSB +: DISP_W];
  assign modeIn  = placeMode_t'(instr[MODE_LSB +: MODE_W]);
  assign gprIdx  = instr[BASE_LSB +: GIDX_W];
  assign effAddr = gprData + {{(ADDR_W-DISP_W){dispRaw[DISP_W-1]}}, dispRaw};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      destQ <= '0;
      modeQ <= PLACE_LANE0;
    end else if (strobe.capture) begin
      addrQ <= effAddr;
      destQ <= destIdx;
      modeQ <= modeIn;
    end
  end

  assign memReqAddr = addrQ;

  always_comb begin
    unique case (modeQ)
      PLACE_HALFLO: halfPat = {{BYTE_W{1'b0}}, memRspData};
      PLACE_HALFHI: halfPat = {memRspData, {BYTE_W{1'b0}}};
      PLACE_HALFSX: halfPat = {{BYTE_W{memRspData[BYTE_W-1]}}, memRspData};
      default:      halfPat = {memRspData, memRspData};
    endcase
  end

  always_comb begin
    placed = oldVal;
    if (!modeQ[2]) begin
      placed[modeQ[1:0]*BYTE_W +: BYTE_W] = memRspData;
    end else begin
      placed = {HALVES{halfPat}};
    end
  end

  bplXregFile #(.XREG_NUM(XREG_NUM)) uRegs (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (strobe.commit),
    .wrIdx  (destQ),
    .wrData (placed),
    .rdIdxA (destQ),
    .rdDataA(oldVal),
    .rdIdxB (dbgIdx),
    .rdDataB(dbgData)
  );
endmodule

// File: rtl/bytePlaceLoad.sv
`timescale 1ns/1ps
module bytePlaceLoad
  import bplPkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int XREG_NUM = 16,
  parameter int GPR_NUM  = 32,
  localparam int XIDX_W  = $clog2(XREG_NUM),
  localparam int GIDX_W  = $clog2(GPR_NUM)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [INSTR_W-1:0] instr,
  output logic [GIDX_W-1:0]  gprIdx,
  input  logic [ADDR_W-1:0]  gprData,
  output logic               memReqValid,
  input  logic               memReqReady,
  output logic [ADDR_W-1:0]  memReqAddr,
  input  logic               memRspValid,
  input  logic [BYTE_W-1:0]  memRspData,
  output logic               busy,
  output logic               done,
  input  logic [XIDX_W-1:0]  dbgIdx,
  output logic [DATA_W-1:0]  dbgData
);
  ctrlStrobe_t strobe;

  bplCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .memReqValid(memReqValid),
    .busy       (busy),
    .done       (done),
    .strobe     (strobe)
  );

  bplDatapath #(.ADDR_W(ADDR_W), .XREG_NUM(XREG_NUM), .GPR_NUM(GPR_NUM)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .instr      (instr),
    .gprIdx     (gprIdx),
    .gprData    (gprData),
    .memReqAddr (memReqAddr),
    .memRspData (memRspData),
    .dbgIdx     (dbgIdx),
    .dbgData    (dbgData)
  );

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  // R8
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R8
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> $stable(memReqAddr));

  // R9
  done_in_flight_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busy && !memReqValid));
endmodule

// File: tb/bytePlaceLoad_test.sv
`timescale 1ns/10ps
module bytePlaceLoad_test;
  typedef struct {
    logic [31:0] addr;
    int          dest;
    logic [31:0] value;
    int          mode;
  } item_t;

  logic        clk = 0;
  logic        rstN = 0;
  logic        start = 0;
  logic [31:0] instr = '0;
  logic [4:0]  gprIdx;
  logic [31:0] gprData;
  logic        memReqValid;
  logic        memReqReady = 0;
  logic [31:0] memReqAddr;
  logic        memRspValid = 0;
  logic [7:0]  memRspData = '0;
  logic        busy, done;
  logic [3:0]  dbgIdx = '0;
  logic [31:0] dbgData;

  int checks = 0, errors = 0, issued = 0, reqCount = 0;
  int readyLag = 0, rspLag = 0;
  logic [31:0] lastAddr = '0;
  logic [31:0] gprModel [32];
  logic [31:0] drvModel [16];
  logic [31:0] monModel [16];
  item_t sbQ [$];
  logic [31:0] lcg = 32'h1234_5678;

  always #2.5 clk = ~clk;

  assign gprData = gprModel[gprIdx];

  bytePlaceLoad uut (
    .clk(clk), .rstN(rstN), .start(start), .instr(instr),
    .gprIdx(gprIdx), .gprData(gprData),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .busy(busy), .done(done), .dbgIdx(dbgIdx), .dbgData(dbgData)
  );

  function automatic logic [7:0] memByte(input logic [31:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  function automatic logic [31:0] placeRef(input int mode, input logic [31:0] old, input logic [7:0] b);
    logic [31:0] r;
    r = old;
    case (mode)
      0: r[7:0]   = b;
      1: r[15:8]  = b;
      2: r[23:16] = b;
      3: r[31:24] = b;
      4: r = {8'h00, b, 8'h00, b};
      5: r = {b, 8'h00, b, 8'h00};
      6: r = {{8{b[7]}}, b, {8{b[7]}}, b};
      default: r = {b, b, b, b};
    endcase
    return r;
  endfunction

  function automatic logic [31:0] mkInstr(input logic [4:0] base, input logic [2:0] opt,
                                          input logic [7:0] disp, input logic [3:0] dest);
    return {6'b011100, base, opt, disp, dest, 6'b111000};
  endfunction

  function automatic string modeTag(input int mode);
    if (mode < 4) return "R3";
    if (mode == 4) return "R4";
    if (mode == 5) return "R5";
    if (mode == 6) return "R6";
    return "R7";
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [4:0] base, input logic [2:0] opt, input logic [7:0] disp,
                       input logic [3:0] dest, input bit intrude, input bit checkIdx);
    logic [31:0] a, v;
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    instr = mkInstr(base, opt, disp, dest);
    #0.1;
    if (checkIdx) chk(gprIdx == base, "R1 base index", {27'd0, gprIdx}, {27'd0, base});
    start = 1;
    a = gprModel[base] + {{24{disp[7]}}, disp};
    v = placeRef(int'(opt), drvModel[dest], memByte(a));
    if (dest != 0) drvModel[dest] = v;
    it.addr = a; it.dest = int'(dest); it.value = v; it.mode = int'(opt);
    sbQ.push_back(it);
    issued++;
    @(negedge clk);
    start = 0;
    if (intrude) begin
      // R8: a start while busy must be ignored
      instr = mkInstr(base ^ 5'd1, 3'd7, 8'h11, dest ^ 4'd1);
      start = 1;
      @(negedge clk);
      start = 0;
    end
  endtask

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      memReqReady = 0;
      memRspValid = 0;
      if (memReqValid) begin
        repeat (readyLag) @(negedge clk);
        memReqReady = 1;
        lastAddr = memReqAddr;
        reqCount++;
        @(negedge clk);
        memReqReady = 0;
        repeat (rspLag) @(negedge clk);
        memRspValid = 1;
        memRspData = memByte(lastAddr);
        @(negedge clk);
        memRspValid = 0;
      end
    end
  end

  // scoreboard monitor
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      if (done && rstN) begin
        if (sbQ.size() == 0) begin
          chk(1'b0, "R8 unexpected completion", 32'd1, 32'd0);
        end else begin
          it = sbQ.pop_front();
          chk(lastAddr == it.addr, "R2 address", lastAddr, it.addr);
          if (it.dest != 0) monModel[it.dest] = it.value;
          @(posedge clk);
          #1;
          chk(!done, "R9 done pulse", {31'd0, done}, 32'd0);
          for (int i = 0; i < 16; i++) begin
            dbgIdx = 4'(i);
            #0.1;
            if (i == 0)
              chk(dbgData == 32'd0, "R10 reg0", dbgData, 32'd0);
            else if (i == it.dest)
              chk(dbgData == monModel[i], modeTag(it.mode), dbgData, monModel[i]);
            else
              chk(dbgData == monModel[i], "R9 other reg", dbgData, monModel[i]);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) gprModel[i] = (i == 0) ? 32'd0 : 32'h0001_0000 + i * 32'h0000_0137;
    gprModel[9] = 32'h0000_2000;
    for (int i = 0; i < 16; i++) begin
      drvModel[i] = '0;
      monModel[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy, "R11 busy", {31'd0, busy}, 32'd0);
    chk(!done, "R11 done", {31'd0, done}, 32'd0);
    chk(!memReqValid, "R11 req", {31'd0, memReqValid}, 32'd0);
    for (int i = 0; i < 16; i++) begin
      dbgIdx = 4'(i);
      #0.1;
      chk(dbgData == 32'd0, "R11 reg zero", dbgData, 32'd0);
    end
    rstN = 1;

    // R7 fill then R3 lane inserts (R1 field decode)
    issue(5'd4, 3'd7, 8'h02, 4'd3, 1'b0, 1'b1);
    issue(5'd5, 3'd0, 8'h10, 4'd3, 1'b0, 1'b1);
    readyLag = 2;
    issue(5'd6, 3'd1, 8'h21, 4'd3, 1'b0, 1'b0);
    rspLag = 3;
    issue(5'd7, 3'd2, 8'h32, 4'd3, 1'b0, 1'b0);
    issue(5'd8, 3'd3, 8'h43, 4'd3, 1'b0, 1'b0);
    readyLag = 0; rspLag = 0;
    // R4 R5 on a preloaded register
    issue(5'd4, 3'd7, 8'h55, 4'd5, 1'b0, 1'b0);
    issue(5'd3, 3'd4, 8'h0C, 4'd5, 1'b0, 1'b0);
    issue(5'd3, 3'd5, 8'h0D, 4'd5, 1'b0, 1'b0);
    // R6 negative byte via negative displacement (R2), then positive byte
    issue(5'd9, 3'd6, 8'h99, 4'd6, 1'b0, 1'b0);
    issue(5'd9, 3'd6, 8'h7B, 4'd7, 1'b0, 1'b0);
    // R10 write to register 0 discarded
    issue(5'd2, 3'd7, 8'h01, 4'd0, 1'b0, 1'b0);
    // R8 start while busy
    readyLag = 1; rspLag = 2;
    issue(5'd10, 3'd0, 8'h04, 4'd8, 1'b1, 1'b0);
    readyLag = 0; rspLag = 1;
    issue(5'd11, 3'd5, 8'hF8, 4'd9, 1'b1, 1'b0);

    for (int n = 0; n < 48; n++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      readyLag = int'(lcg[1:0]) % 3;
      rspLag = int'(lcg[3:2]) % 3;
      issue(lcg[8:4], lcg[11:9], lcg[19:12], lcg[23:20], lcg[24], 1'b0);
    end

    repeat (4) @(negedge clk);
    while (busy || sbQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(reqCount == issued, "R8 request count", 32'(reqCount), 32'(issued));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule